// File: doc/BRIEF.md
# Time-of-Day Clock Core

The block keeps a free-running time counter split into whole seconds and nanoseconds. Software reaches it through a 32-bit register port that writes in one cycle and reads combinationally. On every cycle where the tick input is high and the clock is enabled, the nanosecond count moves forward by a fixed step. When it reaches one billion, it wraps and carries into the seconds count.

To read the time, software sets a request bit and waits for a done flag. The seconds and nanoseconds it then reads were captured together on one edge, so the pair never tears. To set the time, software writes the adjust values and pulses a load bit. It can also pulse an offset bit, which adds a nanosecond offset to the running time. Both writes of time are accepted only when two conditions hold: the source select names the register-driven source, and the external lock input is low.

A select register holds the active source code. On each write, the select register moves the old code into its upper half, so software can put it back afterwards. A fixed version word and a lock status bit complete the map.

Top module: `tod_clock_core`

## Requirements
- R1: Control bit 0 (byte offset 0x00) reads back as written. The time holds still while it is 0, and moves only on cycles where both it and `tick` are 1.
- R2: Each counted tick adds STEP_NS (default 4) nanoseconds. A sum at or above 1,000,000,000 wraps by one billion and adds one to seconds, so nanoseconds always read below one billion.
- R3: Writing control with bit 30 set clears done (bit 31) and sets bit 30. On the next edge, the snapshot nanoseconds (0x10) and seconds (0x14) capture the live time, bit 30 clears and done sets. The snapshot registers change only on that edge.
- R4: A control write with bit 1 set, when accepted, shows bit 1 set until the next edge. On that edge the time becomes the adjust seconds (0x24) and adjust nanoseconds (0x20), and bit 1 clears.
- R5: The load (bit 1) and offset (bit 2) requests are dropped, and the time stays unchanged, when `ref_locked` is 1 or the active source code is not 6.
- R6: A control write with bit 2 set, when accepted, adds the offset nanoseconds (0x30) to the time on the next edge, with carry into seconds.
- R7: Writes to adjust nanoseconds or offset nanoseconds of one billion or more are stored and read back as 999,999,999. The offset window (0x34) stores any value.
- R8: A write to select (0x08) sets the active code to wdata[2:0] and moves the old active code into bits 18:16. Reads return the previous code in bits 31:16 and the active code in bits 2:0. Codes: 0 none, 1 time-of-day, 2 IRIG, 3 PPS, 4 PTP, 5 RTC, 6 registers, 7 external.
- R9: Version (0x0C) reads {major[31:24], minor[23:16], build[15:0]} from parameters (default 0x0102_0003), and writes to it are ignored.
- R10: Status bit 0 (0x04) equals the `ref_locked` input.
- R11: After reset, control, select, the snapshot and the time read 0. Reserved offsets read 0 and ignore writes.
- R12: When a snapshot request and an accepted load are written together, the snapshot holds the time from before the load, and the load still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe derived from the core clock |
| ref_locked | input | 1 | High while an external reference disciplines the clock |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |

## Verification
The snapshot capture and the counter load can land on the same edge when one control write carries both the request bit and the load bit. The bench sets the time to a known value and then writes both bits together. It expects the first snapshot to hold the time from before the load, and a second snapshot to hold the adjust values. A load carried in with an offset-wrap case, plus a load that is refused while a snapshot completes, separate a correct pre-update capture from one that reads the new value.

// File: rtl/tod_clock_pkg.sv
package tod_clock_pkg;
   localparam int unsigned REG_W = 32;
   localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;
   localparam logic [31:0] NS_MAX     = 32'd999_999_999;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0, SRC_TOD = 3'd1, SRC_IRIG = 3'd2, SRC_PPS = 3'd3,
      SRC_PTP  = 3'd4, SRC_RTC = 3'd5, SRC_REGS = 3'd6, SRC_EXT = 3'd7
   } src_e;

   // byte offsets of the register words
   localparam logic [7:0] OFS_CTRL    = 8'h00;
   localparam logic [7:0] OFS_STATUS  = 8'h04;
   localparam logic [7:0] OFS_SELECT  = 8'h08;
   localparam logic [7:0] OFS_VERSION = 8'h0C;
   localparam logic [7:0] OFS_SNAP_NS = 8'h10;
   localparam logic [7:0] OFS_SNAP_S  = 8'h14;
   localparam logic [7:0] OFS_ADJ_NS  = 8'h20;
   localparam logic [7:0] OFS_ADJ_S   = 8'h24;
   localparam logic [7:0] OFS_OFF_NS  = 8'h30;
   localparam logic [7:0] OFS_OFF_WIN = 8'h34;

   // control bit positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_ADJ  = 1;
   localparam int unsigned CB_OFF  = 2;
   localparam int unsigned CB_REQ  = 30;
   localparam int unsigned CB_DONE = 31;

   function automatic logic [31:0] clamp_ns(input logic [31:0] v);
      return (v > NS_MAX) ? NS_MAX : v;
   endfunction
endpackage

// File: rtl/tod_time_counter.sv
module tod_time_counter
   import tod_clock_pkg::*;
#(
   parameter int unsigned STEP_NS = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        tick,
   input  logic        load,
   input  logic [31:0] load_sec,
   input  logic [31:0] load_ns,
   input  logic        add_off,
   input  logic [31:0] off_ns,
   output logic [31:0] sec,
   output logic [31:0] ns
);
   localparam logic [33:0] ONE_SEC = 34'(NS_PER_SEC);
   localparam logic [33:0] TWO_SEC = 34'(NS_PER_SEC) << 1;
   localparam logic [33:0] STEP    = 34'(STEP_NS);

   logic [33:0] sum;
   logic [31:0] ns_nxt;
   logic [1:0]  carry;

   always_comb begin
      sum = {2'b00, ns}
          + ((en && tick) ? STEP : 34'd0)
          + (add_off ? {2'b00, off_ns} : 34'd0);
      if (sum >= TWO_SEC) begin
         ns_nxt = 32'(sum - TWO_SEC);
         carry  = 2'd2;
      end else if (sum >= ONE_SEC) begin
         ns_nxt = 32'(sum - ONE_SEC);
         carry  = 2'd1;
      end else begin
         ns_nxt = 32'(sum);
         carry  = 2'd0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec <= '0;
         ns  <= '0;
      end else if (load) begin
         sec <= load_sec;
         ns  <= load_ns;
      end else begin
         sec <= sec + 32'(carry);
         ns  <= ns_nxt;
      end
   end
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot
   import tod_clock_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [REG_W-1:0] live_sec,
   input  logic [REG_W-1:0] live_ns,
   output logic [REG_W-1:0] snap_sec,
   output logic [REG_W-1:0] snap_ns,
   output logic             busy,
   output logic             done
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_sec <= '0;
         snap_ns  <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else if (arm) begin
         busy <= 1'b1;
         done <= 1'b0;
      end else if (busy) begin
         snap_sec <= live_sec;
         snap_ns  <= live_ns;
         busy     <= 1'b0;
         done     <= 1'b1;
      end
   end
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
   import tod_clock_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STEP_NS   = 4,
   parameter int unsigned VER_MAJOR = 1,
   parameter int unsigned VER_MINOR = 2,
   parameter int unsigned VER_BUILD = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ref_locked,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   localparam logic [31:0] VERSION_WORD =
      {8'(VER_MAJOR), 8'(VER_MINOR), 16'(VER_BUILD)};

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x34");
   end
   if (STEP_NS == 0 || STEP_NS >= 32'd1_000_000_000) begin : g_bad_step
      $error("STEP_NS must lie in 1 .. 999999999");
   end
   if (VER_MAJOR > 255 || VER_MINOR > 255 || VER_BUILD > 65535) begin : g_bad_ver
      $error("version field out of range");
   end

   logic        enable, adj_pend, off_pend;
   src_e        src_cur, src_prev;
   logic [31:0] adj_ns, adj_sec, off_ns, off_win;
   logic [31:0] cur_sec, cur_ns, snap_sec, snap_ns;
   logic        snap_busy, snap_done;
   logic        ctrl_wr, snap_arm, set_ok;

   assign ctrl_wr  = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
   assign snap_arm = ctrl_wr && reg_wdata[CB_REQ];
   assign set_ok   = !ref_locked && (src_cur == SRC_REGS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         adj_pend <= 1'b0;
         off_pend <= 1'b0;
         src_cur  <= SRC_NONE;
         src_prev <= SRC_NONE;
         adj_ns   <= '0;
         adj_sec  <= '0;
         off_ns   <= '0;
         off_win  <= '0;
      end else begin
         adj_pend <= ctrl_wr && reg_wdata[CB_ADJ] && set_ok;
         off_pend <= ctrl_wr && reg_wdata[CB_OFF] && set_ok;
         if (ctrl_wr) enable <= reg_wdata[CB_EN];
         if (reg_we) begin
            case (reg_addr)
               ADDR_W'(OFS_SELECT): begin
                  src_prev <= src_cur;
                  src_cur  <= src_e'(reg_wdata[2:0]);
               end
               ADDR_W'(OFS_ADJ_NS):  adj_ns  <= clamp_ns(reg_wdata);
               ADDR_W'(OFS_ADJ_S):   adj_sec <= reg_wdata;
               ADDR_W'(OFS_OFF_NS):  off_ns  <= clamp_ns(reg_wdata);
               ADDR_W'(OFS_OFF_WIN): off_win <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   tod_time_counter #(.STEP_NS(STEP_NS)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (enable),
      .tick     (tick),
      .load     (adj_pend),
      .load_sec (adj_sec),
      .load_ns  (adj_ns),
      .add_off  (off_pend),
      .off_ns   (off_ns),
      .sec      (cur_sec),
      .ns       (cur_ns)
   );

   tod_snapshot i_snapshot (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (snap_arm),
      .live_sec (cur_sec),
      .live_ns  (cur_ns),
      .snap_sec (snap_sec),
      .snap_ns  (snap_ns),
      .busy     (snap_busy),
      .done     (snap_done)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_CTRL): begin
            reg_rdata[CB_EN]   = enable;
            reg_rdata[CB_ADJ]  = adj_pend;
            reg_rdata[CB_OFF]  = off_pend;
            reg_rdata[CB_REQ]  = snap_busy;
            reg_rdata[CB_DONE] = snap_done;
         end
         ADDR_W'(OFS_STATUS):  reg_rdata[0] = ref_locked;
         ADDR_W'(OFS_SELECT):  reg_rdata = {13'd0, src_prev, 13'd0, src_cur};
         ADDR_W'(OFS_VERSION): reg_rdata = VERSION_WORD;
         ADDR_W'(OFS_SNAP_NS): reg_rdata = snap_ns;
         ADDR_W'(OFS_SNAP_S):  reg_rdata = snap_sec;
         ADDR_W'(OFS_ADJ_NS):  reg_rdata = adj_ns;
         ADDR_W'(OFS_ADJ_S):   reg_rdata = adj_sec;
         ADDR_W'(OFS_OFF_NS):  reg_rdata = off_ns;
         ADDR_W'(OFS_OFF_WIN): reg_rdata = off_win;
         default:              reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker
   import tod_clock_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              ref_locked,
   input logic              enable,
   input logic              adj_pend,
   input logic              off_pend,
   input logic              snap_arm,
   input logic              snap_busy,
   input logic              snap_done,
   input logic [31:0]       cur_ns,
   input logic [31:0]       cur_sec,
   input logic [31:0]       adj_ns,
   input logic [31:0]       adj_sec,
   input logic [31:0]       snap_ns,
   input logic [31:0]       snap_sec
);
   logic ctrl_wr;
   assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));

   AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !adj_pend && !off_pend) |=> ($stable(cur_ns) && $stable(cur_sec))); // R1
   AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_ns < NS_PER_SEC); // R2
   AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_busy && !snap_arm) |=> (snap_done && !snap_busy)); // R3
   AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_busy |=> ($stable(snap_ns) && $stable(snap_sec))); // R3
   AST_LOAD_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      adj_pend |=> (cur_ns == $past(adj_ns) && cur_sec == $past(adj_sec))); // R4
   AST_ADJ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_pend && !ctrl_wr) |=> !adj_pend); // R4
   AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ref_locked |=> (!adj_pend && !off_pend)); // R5
   AST_ADJ_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      adj_ns <= NS_MAX); // R7
endmodule

bind tod_clock_core tod_clock_checker #(.ADDR_W(ADDR_W)) i_tod_clock_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .ref_locked (ref_locked),
   .enable     (enable),
   .adj_pend   (adj_pend),
   .off_pend   (off_pend),
   .snap_arm   (snap_arm),
   .snap_busy  (snap_busy),
   .snap_done  (snap_done),
   .cur_ns     (cur_ns),
   .cur_sec    (cur_sec),
   .adj_ns     (adj_ns),
   .adj_sec    (adj_sec),
   .snap_ns    (snap_ns),
   .snap_sec   (snap_sec)
);

// File: tb/test_tod_clock_core.sv
`timescale 1ns/1ps
module test_tod_clock_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        ref_locked = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tod_clock_core i_tod_clock_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .ref_locked (ref_locked),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata)
   );

   localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_SEL = 8'h08, A_VER = 8'h0C;
   localparam logic [7:0] A_SNS = 8'h10, A_SS = 8'h14, A_ANS = 8'h20, A_AS = 8'h24;
   localparam logic [7:0] A_ONS = 8'h30, A_OWIN = 8'h34;

   // {tag[3:0], we, addr[7:0], wdata[31:0], expected[31:0]}
   localparam int NV = 13;
   localparam logic [76:0] VEC [NV] = '{
      {4'd7,  1'b1, A_ANS,  32'hFFFF_FFFF, 32'h3B9A_C9FF},  // R7 clamp
      {4'd7,  1'b1, A_ANS,  32'd123,       32'd123},        // R7 small value kept
      {4'd7,  1'b1, A_AS,   32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R7 seconds raw
      {4'd7,  1'b1, A_ONS,  32'h3B9A_CA00, 32'h3B9A_C9FF},  // R7 offset clamp
      {4'd7,  1'b1, A_OWIN, 32'h0000_0055, 32'h0000_0055},  // R7 window raw
      {4'd8,  1'b1, A_SEL,  32'd6,         32'h0000_0006},  // R8
      {4'd8,  1'b1, A_SEL,  32'd4,         32'h0006_0004},  // R8 history
      {4'd8,  1'b1, A_SEL,  32'h0000_0006, 32'h0004_0006},  // R8 restore
      {4'd8,  1'b1, A_SEL,  32'hFFFF_FFF3, 32'h0006_0003},  // R8 low bits only
      {4'd9,  1'b0, A_VER,  32'd0,         32'h0102_0003},  // R9
      {4'd9,  1'b1, A_VER,  32'd0,         32'h0102_0003},  // R9 read-only
      {4'd11, 1'b1, 8'h18,  32'h0000_FFFF, 32'h0000_0000},  // R11 reserved
      {4'd1,  1'b1, A_CTRL, 32'h0000_0001, 32'h0000_0001}   // R1 enable readback
   };

   task automatic check(input int tag, input string what, input logic [31:0] got,
                        input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", tag, what, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic snap(input logic en, output logic [31:0] s, output logic [31:0] n);
      wr(A_CTRL, {1'b0, 1'b1, 29'd0, en});
      @(negedge clk);
      rd(A_SS, s);
      rd(A_SNS, n);
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, s, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(A_CTRL, v); check(11, "ctrl after reset", v, 32'h0);
      rd(A_SEL, v);  check(11, "select after reset", v, 32'h0);
      rd(A_SS, v);   check(11, "snap sec after reset", v, 32'h0);
      rd(A_STAT, v); check(10, "status unlocked", v, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
         rd(VEC[i][71:64], v);
         check(int'(VEC[i][76:73]), $sformatf("table row %0d", i), v, VEC[i][31:0]);
      end

      // R2 counting: 10 ticks of 4 ns
      run_ticks(10);
      snap(1'b1, s, n);
      check(2, "ns after 10 ticks", n, 32'd40);
      check(2, "sec after 10 ticks", s, 32'd0);

      // R3 handshake sequence
      wr(A_CTRL, 32'h4000_0001);
      rd(A_CTRL, v); check(3, "request pending, done clear", v, 32'h4000_0001);
      @(negedge clk);
      rd(A_CTRL, v); check(3, "done set, request cleared", v, 32'h8000_0001);

      // R1 disabled clock holds
      wr(A_CTRL, 32'h0);
      run_ticks(5);
      snap(1'b0, s, n);
      check(1, "ns frozen while disabled", n, 32'd40);
      wr(A_CTRL, 32'h1);

      // R5 wrong source (PPS active) drops the load
      wr(A_AS, 32'd7);
      wr(A_ANS, 32'd999_999_996);
      wr(A_CTRL, 32'h3);
      rd(A_CTRL, v); check(5, "load refused, source not registers", v, 32'h8000_0001);
      @(negedge clk);
      snap(1'b1, s, n);
      check(5, "time unchanged after refused load", n, 32'd40);

      // R4 load, then R2 wrap
      wr(A_SEL, 32'd6);
      wr(A_CTRL, 32'h3);
      rd(A_CTRL, v); check(4, "load pending", v, 32'h8000_0003);
      @(negedge clk);
      rd(A_CTRL, v); check(4, "load self-cleared", v, 32'h8000_0001);
      snap(1'b1, s, n);
      check(4, "loaded sec", s, 32'd7);
      check(4, "loaded ns", n, 32'd999_999_996);
      run_ticks(1);
      snap(1'b1, s, n);
      check(2, "wrap ns", n, 32'd0);
      check(2, "wrap carry sec", s, 32'd8);

      // R5 lock blocks load; R10 status
      ref_locked = 1'b1;
      rd(A_STAT, v); check(10, "status locked", v, 32'h1);
      wr(A_AS, 32'd100);
      wr(A_CTRL, 32'h3);
      @(negedge clk);
      snap(1'b1, s, n);
      check(5, "sec unchanged under lock", s, 32'd8);
      ref_locked = 1'b0;

      // R6 offset without and with carry
      wr(A_ONS, 32'd500);
      wr(A_CTRL, 32'h5);
      @(negedge clk);
      snap(1'b1, s, n);
      check(6, "offset ns", n, 32'd500);
      wr(A_ONS, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h5);
      @(negedge clk);
      snap(1'b1, s, n);
      check(6, "offset carry ns", n, 32'd499);
      check(6, "offset carry sec", s, 32'd9);

      // R12 snapshot and load on the same edge
      wr(A_AS, 32'd20);
      wr(A_ANS, 32'd40);
      wr(A_CTRL, 32'h4000_0003);
      @(negedge clk);
      rd(A_SS, s); rd(A_SNS, n);
      check(12, "snapshot sec pre-load", s, 32'd9);
      check(12, "snapshot ns pre-load", n, 32'd499);
      snap(1'b1, s, n);
      check(12, "load applied sec", s, 32'd20);
      check(12, "load applied ns", n, 32'd40);

      // R11 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(A_CTRL, v); check(11, "ctrl after second reset", v, 32'h0);
      rd(A_SNS, v);  check(11, "snap ns after second reset", v, 32'h0);
      snap(1'b0, s, n);
      check(11, "time cleared by reset", s, 32'd0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule